// File: doc/BRIEF.md
# Single-Slope PWM Timer with Selectable Wrap Point

This block is an up-counting timer that turns a counter sweep into pulse-width modulated waveforms on two outputs, A and B. A free-running divider produces a one-cycle count enable at one of seven division ratios, or none at all. The counter either runs over its full range and wraps from all-ones to zero, or it wraps after reaching the active value of compare register A. The second choice trades away channel A's waveform for a freely chosen period.

Software writes through a synchronous four-address port. A control byte selects the wrap source, the output polarity of each channel and the division ratio, and it takes effect at once. The two compare values are written into buffers and move into their active copies only when the counter wraps. This applies to the compare value that sets the period as well. As a result, writes can land at any point in a period without producing a short or a stretched cycle. Three sticky status flags report compare matches and wraps, and software clears each one by writing a 1 to its bit.

Top module: `fpwm_timer`

## Requirements
- R1: After reset the count is 0, both outputs are low, all three flags are clear, and the control byte is 0 (timer stopped, full-range wrap, outputs off), so the count stays at 0.
- R2: With control bit 0 at 0, the count steps 0, 1, …, 255 and then returns to 0, giving 256 counts per period.
- R3: With control bit 0 at 1, the count wraps to 0 after reaching the active compare A value T, giving T+1 counts per period, and output A is held low whatever its output mode.
- R4: Control bits 7:5 select the clock cycles per count. Code 0 stops the counter. Codes 1 to 7 give 1, 8, 32, 64, 128, 256 and 1024 cycles per count.
- R5: Output mode code 2'b10 (bits 2:1 for channel A, bits 4:3 for channel B) drives the output high while the count is at most the channel's active compare value C, so it is high for C+1 counts per period starting at count 0.
- R6: Output mode 2'b11 produces the complement of the R5 waveform. Modes 2'b00 and 2'b01 hold the output low.
- R7: When channel B's active compare value exceeds the wrap point, a channel B output in mode 2'b10 stays high for the entire period.
- R8: Writes to address 1 (compare A) or address 2 (compare B) change the output only from the next wrap onward; the current period keeps the old value.
- R9: A new, smaller wrap value written in the middle of a period does not end that period early. The period still ends at the old value, and the next period uses the new one.
- R10: The compare flag of a channel sets on a count step taken while the count equals that channel's active compare value. The overflow flag sets on a wrap step.
- R11: Writing to address 3 clears the flags whose data bits are 1 (bit 0 compare A, bit 1 compare B, bit 2 overflow). Bits written as 0 leave their flags unchanged. A flag that sets in the same cycle as its clear stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 2 | 0 control, 1 compare A buffer, 2 compare B buffer, 3 flag clear |
| wr_data | input | CNT_W | Write data |
| count | output | CNT_W | Present counter value |
| pwm_a | output | 1 | Channel A waveform |
| pwm_b | output | 1 | Channel B waveform |
| flag_cmp_a | output | 1 | Channel A compare flag |
| flag_cmp_b | output | 1 | Channel B compare flag |
| flag_ovf | output | 1 | Wrap (overflow) flag |

## Verification
A software clear of the overflow flag can arrive in the same clock edge as the wrap step that sets it. The bench runs the counter at one count per cycle and watches for the all-ones count at a falling edge. It then drives the clear write so that it lands on exactly the edge where the wrap occurs, and requires the flag to read 1 afterwards. A second pairing is a compare buffer write that coincides with a count inside the current period. The bench times it and judges it by checking that the output keeps the old duty until the wrap.

// File: rtl/fpwm_pkg.sv
`timescale 1ns/1ps
package fpwm_pkg;
   typedef enum logic [1:0] {
      OUT_OFF  = 2'b00,
      OUT_RSV  = 2'b01,
      OUT_NORM = 2'b10,
      OUT_INV  = 2'b11
   } out_mode_e;

   localparam logic [1:0] ADR_CTRL = 2'd0;
   localparam logic [1:0] ADR_CMPA = 2'd1;
   localparam logic [1:0] ADR_CMPB = 2'd2;
   localparam logic [1:0] ADR_FCLR = 2'd3;

   typedef struct packed {
      logic [2:0] psel;
      out_mode_e  mode_b;
      out_mode_e  mode_a;
      logic       var_top;
   } ctrl_t;
endpackage

// File: rtl/fpwm_prescaler.sv
`timescale 1ns/1ps
module fpwm_prescaler #(
   parameter int DIV_W = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] psel,
   output logic       tick
);
   initial begin
      assert (DIV_W >= 10) else $error("DIV_W must hold a divide by 1024");
   end

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] mask;

   always_ff @(posedge clk) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + 1'b1;
   end

   always_comb begin
      case (psel)
         3'd2:    mask = DIV_W'(7);
         3'd3:    mask = DIV_W'(31);
         3'd4:    mask = DIV_W'(63);
         3'd5:    mask = DIV_W'(127);
         3'd6:    mask = DIV_W'(255);
         3'd7:    mask = DIV_W'(1023);
         default: mask = '0;
      endcase
   end

   assign tick = (psel != 3'd0) && ((div_q & mask) == mask);

   AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (psel == 3'd0) |-> !tick);   // R4
endmodule

// File: rtl/fpwm_core.sv
`timescale 1ns/1ps
module fpwm_core #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             var_top,
   input  logic [CNT_W-1:0] cmpa_buf,
   input  logic [CNT_W-1:0] cmpb_buf,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cmpa_act,
   output logic [CNT_W-1:0] cmpb_act,
   output logic             wrap_tick
);
   logic [CNT_W-1:0] top;
   logic             at_wrap;

   assign top       = var_top ? cmpa_act : '1;
   // all-ones also wraps, so a mode change past the active top cannot stall
   assign at_wrap   = (cnt == top) || (cnt == '1);
   assign wrap_tick = tick && at_wrap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt      <= '0;
         cmpa_act <= '0;
         cmpb_act <= '0;
      end else if (tick) begin
         if (at_wrap) begin
            cnt      <= '0;
            cmpa_act <= cmpa_buf;
            cmpb_act <= cmpb_buf;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));   // R4
   AST_FULL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt == '1) |=> (cnt == '0));   // R2
   AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap_tick |=> ($stable(cmpb_act) && $stable(cmpa_act)));   // R8
endmodule

// File: rtl/fpwm_chan.sv
`timescale 1ns/1ps
module fpwm_chan
   import fpwm_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp,
   input  out_mode_e        mode,
   input  logic             force_low,
   output logic             pwm
);
   logic level;
   assign level = (cnt <= cmp);

   always_comb begin
      if (force_low)             pwm = 1'b0;
      else if (mode == OUT_NORM) pwm = level;
      else if (mode == OUT_INV)  pwm = !level;
      else                       pwm = 1'b0;
   end

   AST_BOTTOM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == OUT_NORM && !force_low && cnt == '0) |-> pwm);   // R5
endmodule

// File: rtl/fpwm_flags.sv
`timescale 1ns/1ps
module fpwm_flags #(
   parameter int NFLAG = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NFLAG-1:0] set,
   input  logic [NFLAG-1:0] clr,
   output logic [NFLAG-1:0] flags
);
   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)      flags[i] <= 1'b0;
         else if (set[i]) flags[i] <= 1'b1;
         else if (clr[i]) flags[i] <= 1'b0;
      end

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         set[i] |=> flags[i]);   // R11
      AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !set[i]) |=> !flags[i]);   // R11
   end
endmodule

// File: rtl/fpwm_timer.sv
`timescale 1ns/1ps
module fpwm_timer
   import fpwm_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int DIV_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] count,
   output logic             pwm_a,
   output logic             pwm_b,
   output logic             flag_cmp_a,
   output logic             flag_cmp_b,
   output logic             flag_ovf
);
   localparam int NCH = 2;

   initial begin
      assert (CNT_W >= 8) else $error("CNT_W must hold the control byte");
   end

   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] cmpa_buf, cmpb_buf;
   logic [CNT_W-1:0] cnt, cmpa_act, cmpb_act;
   logic             tick, wrap_tick;
   logic [2:0]       fset, fclr, fq;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         cmpa_buf <= '0;
         cmpb_buf <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            ADR_CTRL: ctrl_q   <= ctrl_t'(wr_data[7:0]);
            ADR_CMPA: cmpa_buf <= wr_data;
            ADR_CMPB: cmpb_buf <= wr_data;
            default:  ;
         endcase
      end
   end

   fpwm_prescaler #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .psel(ctrl_q.psel), .tick(tick));

   fpwm_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .var_top(ctrl_q.var_top),
      .cmpa_buf(cmpa_buf), .cmpb_buf(cmpb_buf), .cnt(cnt),
      .cmpa_act(cmpa_act), .cmpb_act(cmpb_act), .wrap_tick(wrap_tick));

   logic [CNT_W-1:0] ch_cmp   [NCH];
   out_mode_e        ch_mode  [NCH];
   logic             ch_force [NCH];
   logic             ch_pwm   [NCH];

   assign ch_cmp[0]   = cmpa_act;
   assign ch_cmp[1]   = cmpb_act;
   assign ch_mode[0]  = ctrl_q.mode_a;
   assign ch_mode[1]  = ctrl_q.mode_b;
   assign ch_force[0] = ctrl_q.var_top;
   assign ch_force[1] = 1'b0;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      fpwm_chan #(.CNT_W(CNT_W)) u_ch (
         .clk(clk), .rst_n(rst_n), .cnt(cnt), .cmp(ch_cmp[c]),
         .mode(ch_mode[c]), .force_low(ch_force[c]), .pwm(ch_pwm[c]));
   end

   assign fset[0] = tick && (cnt == cmpa_act);
   assign fset[1] = tick && (cnt == cmpb_act);
   assign fset[2] = wrap_tick;
   assign fclr    = (wr_en && wr_addr == ADR_FCLR) ? wr_data[2:0] : 3'b000;

   fpwm_flags #(.NFLAG(3)) u_flags (
      .clk(clk), .rst_n(rst_n), .set(fset), .clr(fclr), .flags(fq));

   assign count      = cnt;
   assign pwm_a      = ch_pwm[0];
   assign pwm_b      = ch_pwm[1];
   assign flag_cmp_a = fq[0];
   assign flag_cmp_b = fq[1];
   assign flag_ovf   = fq[2];

   AST_VAR_A_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q.var_top |-> !pwm_a);   // R3
   AST_VAR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.var_top && $past(ctrl_q.var_top) && $past(wrap_tick)) |-> (cnt <= cmpa_act));   // R9
endmodule

// File: tb/sim_fpwm_timer.sv
`timescale 1ns/1ps
module sim_fpwm_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] count;
   logic       pwm_a, pwm_b, flag_cmp_a, flag_cmp_b, flag_ovf;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   fpwm_timer u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .count(count), .pwm_a(pwm_a), .pwm_b(pwm_b),
      .flag_cmp_a(flag_cmp_a), .flag_cmp_b(flag_cmp_b), .flag_ovf(flag_ovf));

   localparam logic [1:0] M_OFF = 2'b00, M_RSV = 2'b01, M_NORM = 2'b10, M_INV = 2'b11;

   function automatic logic [7:0] mk(input int ps, input logic [1:0] mb,
                                     input logic [1:0] ma, input bit v);
      return {ps[2:0], mb, ma, v};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_val(input int v);
      do @(negedge clk); while (count != v[7:0]);
   endtask

   task automatic wait_bottom();
      do @(negedge clk); while (count == 8'd0);
      while (count != 8'd0) @(negedge clk);
   endtask

   // from a negedge with count 0, sample n cycles
   task automatic measure(input int n, output int hia, output int hib, output int mx);
      hia = 0; hib = 0; mx = 0;
      for (int i = 0; i < n; i++) begin
         hia += int'(pwm_a); hib += int'(pwm_b);
         if (int'(count) > mx) mx = int'(count);
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      chk(count == 0, "R1 count", count, 0);
      chk(pwm_a == 0 && pwm_b == 0, "R1 outputs", {pwm_a, pwm_b}, 0);
      chk({flag_cmp_a, flag_cmp_b, flag_ovf} == 0, "R1 flags",
          {flag_cmp_a, flag_cmp_b, flag_ovf}, 0);
      repeat (20) @(negedge clk);
      chk(count == 0, "R1 stopped", count, 0);
   endtask

   task automatic t_fixed();
      int ha, hb, mx;
      wr(2'd1, 8'd100);
      wr(2'd2, 8'd63);
      wr(2'd0, mk(1, M_NORM, M_NORM, 0));
      wait_bottom(); wait_bottom();
      measure(256, ha, hb, mx);
      chk(hb == 64, "R5 B high counts", hb, 64);
      chk(ha == 101, "R5 A high counts", ha, 101);
      chk(mx == 255, "R2 max count", mx, 255);
      chk(count == 0, "R2 wrap to 0", count, 0);
   endtask

   task automatic t_inv();
      int ha, hb, mx;
      wr(2'd0, mk(1, M_INV, M_OFF, 0));
      wait_bottom();
      measure(256, ha, hb, mx);
      chk(hb == 192, "R6 inverted B", hb, 192);
      chk(ha == 0, "R6 off A", ha, 0);
      wr(2'd0, mk(1, M_OFF, M_RSV, 0));
      wait_bottom();
      measure(256, ha, hb, mx);
      chk(ha == 0 && hb == 0, "R6 reserved/off low", ha + hb, 0);
   endtask

   task automatic t_var();
      int ha, hb, mx;
      wr(2'd1, 8'd9);
      wr(2'd2, 8'd3);
      wr(2'd0, mk(1, M_NORM, M_NORM, 1));
      wait_bottom(); wait_bottom();
      measure(10, ha, hb, mx);
      chk(hb == 4, "R5 B duty var top", hb, 4);
      chk(ha == 0, "R3 A held low", ha, 0);
      chk(mx == 9, "R3 max count", mx, 9);
      chk(count == 0, "R3 period 10", count, 0);
   endtask

   task automatic t_full();
      int ha, hb, mx;
      wr(2'd2, 8'd15);
      wait_bottom(); wait_bottom();
      measure(10, ha, hb, mx);
      chk(hb == 10, "R7 full duty", hb, 10);
   endtask

   task automatic t_buf();
      int ha, hb, mx;
      wr(2'd2, 8'd5);
      wait_bottom(); wait_bottom();
      wait_val(2);
      wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'd1;
      @(negedge clk);
      wr_en = 1'b0;
      wait_val(4);
      chk(pwm_b == 1, "R8 old value kept", pwm_b, 1);
      wait_bottom();
      measure(10, ha, hb, mx);
      chk(hb == 2, "R8 new value after wrap", hb, 2);
   endtask

   task automatic t_top();
      int mx, len;
      wr(2'd1, 8'd200);
      wait_bottom(); wait_bottom();
      wait_val(150);
      wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'd20;
      @(negedge clk);
      wr_en = 1'b0;
      mx = 0;
      while (count != 0) begin
         if (int'(count) > mx) mx = int'(count);
         @(negedge clk);
      end
      chk(mx == 200, "R9 old top finishes", mx, 200);
      len = 0;
      do begin len++; @(negedge clk); end while (count != 0 && len < 400);
      chk(len == 21, "R9 new period", len, 21);
   endtask

   task automatic presc_one(input int code, input int n);
      int len;
      logic [7:0] c0;
      wr(2'd0, mk(code, M_NORM, M_OFF, 1));
      c0 = count;
      while (count == c0) @(negedge clk);
      c0 = count; len = 0;
      while (count == c0 && len < 3000) begin len++; @(negedge clk); end
      chk(len == n, $sformatf("R4 code %0d", code), len, n);
   endtask

   task automatic t_presc();
      logic [7:0] c0;
      presc_one(2, 8);
      presc_one(3, 32);
      presc_one(5, 128);
      presc_one(7, 1024);
      wr(2'd0, mk(0, M_NORM, M_OFF, 1));
      c0 = count;
      repeat (100) @(negedge clk);
      chk(count == c0, "R4 stop holds", count, c0);
   endtask

   task automatic t_flags();
      wr(2'd0, mk(0, M_OFF, M_OFF, 0));
      wr(2'd3, 8'h07);
      chk({flag_cmp_a, flag_cmp_b, flag_ovf} == 0, "R11 clear all",
          {flag_cmp_a, flag_cmp_b, flag_ovf}, 0);
      wr(2'd1, 8'd100);
      wr(2'd2, 8'd50);
      wr(2'd0, mk(1, M_NORM, M_NORM, 0));
      wait_bottom();
      wr(2'd3, 8'h07);
      wait_val(50);
      chk(flag_cmp_b == 0, "R10 B not yet", flag_cmp_b, 0);
      @(negedge clk);
      chk(flag_cmp_b == 1, "R10 B set at match", flag_cmp_b, 1);
      wait_val(120);
      chk(flag_cmp_a == 1, "R10 A set", flag_cmp_a, 1);
      wr(2'd3, 8'h00);
      chk(flag_cmp_a == 1 && flag_cmp_b == 1, "R11 zero bits ignored",
          {flag_cmp_a, flag_cmp_b}, 3);
      wr(2'd3, 8'h02);
      chk(flag_cmp_b == 0 && flag_cmp_a == 1, "R11 clear B only",
          {flag_cmp_a, flag_cmp_b}, 2);
      wr(2'd3, 8'h04);
      wait_val(255);
      chk(flag_ovf == 0, "R10 ovf before wrap", flag_ovf, 0);
      @(negedge clk);
      chk(flag_ovf == 1, "R10 ovf at wrap", flag_ovf, 1);
      wr(2'd3, 8'h04);
      chk(flag_ovf == 0, "R11 ovf cleared", flag_ovf, 0);
      wait_val(255);
      wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h04;
      @(negedge clk);
      wr_en = 1'b0;
      chk(flag_ovf == 1, "R11 set wins over clear", flag_ovf, 1);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fixed();
      t_inv();
      t_var();
      t_full();
      t_buf();
      t_top();
      t_presc();
      t_flags();
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule